// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block sits on the host side of a PCI hierarchy and turns port-style accesses into configuration-space transactions. Software first loads a 32-bit address register that selects an enable bit, a bus, a device/function and a register offset. It then reads or writes a four-byte data window. Each data-window access whose enable bit is set, whose target exists and whose offset lies inside the configuration space becomes one request on a downstream interface. That interface carries the bus, device/function, register offset, byte lanes and shifted write data, and it returns the read data.

Before a request is issued, the bridge spends one cycle probing whether the target is present. The downstream side answers with level flags that are derived from the bus and device/function outputs. When access is disabled, the target is absent or the offset is out of range, no request is issued: writes are dropped and reads return all ones. The address register can be read back for saving and loaded through a dedicated port for restoring, so an access made after a restore reaches the same target as before.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the address register holds 0 (`state_out` reads 0), `host_ready` is 1, and data-window reads return 32'hFFFFFFFF.
- R2: A host write with `host_sel`=0 changes the address register only when `host_off`=0 and `host_len`=4. Any other address-register write leaves it unchanged.
- R3: A host read with `host_sel`=0 returns the whole 32-bit address register, whatever the offset and length of the read.
- R4: When bit 31 of the address register is 0, a data-window read returns 32'hFFFFFFFF, and neither reads nor writes issue `cfg_req`.
- R5: A forwarded access drives `cfg_bus` = address bits 23:16 and `cfg_devfn` = bits 15:8. It drives `cfg_reg` = address bits 7:0 ORed with the 2-bit window offset. These fields stay stable while `host_ready` is 0.
- R6: `cfg_be` holds the effective byte count as a run of ones, shifted left by `cfg_reg[1:0]` and cut to 4 lanes. Write data is shifted up by 8×`cfg_reg[1:0]` bits. Read data comes back right-justified from lane `cfg_reg[1:0]`, with disabled lanes zero.
- R7: If `dev_present` is 0 in the probe cycle, a read returns 32'hFFFFFFFF and a write is dropped, with no `cfg_req`.
- R8: A target with `dev_hotplug`=1 and a non-zero function number (devfn bits 2:0) is treated as absent (as in R7) when `dev_fn0_present` is 0.
- R9: An offset at or beyond `CFG_LIMIT` returns all ones and issues no `cfg_req`. Otherwise the effective byte count is min(`host_len`, `CFG_LIMIT` − offset), and `cfg_be` is never zero on a request.
- R10: `state_out` always shows the address register. A cycle with `state_ld`=1 loads `state_in`, with priority over a host address write, and later data accesses use the loaded value.
- R11: `cfg_req` and `host_ack` are single-cycle pulses, with one `host_ack` per accepted access. `host_ready` is 0 from an accepted forwarded access until its `host_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, accepted when host_ready is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address register, 1 = data window |
| host_off | input | 2 | Byte offset of the access within its port |
| host_len | input | 3 | Access length in bytes, 1 to 4 |
| host_wdata | input | 32 | Right-justified host write data |
| host_ready | output | 1 | Bridge idle, may accept host_req |
| host_ack | output | 1 | Access complete, host_rdata valid |
| host_rdata | output | 32 | Right-justified read data |
| cfg_req | output | 1 | Downstream configuration request pulse |
| cfg_we | output | 1 | Downstream write flag |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 8 | Target register byte offset |
| cfg_be | output | 4 | Byte lanes of the request |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Downstream dword read data |
| dev_present | input | 1 | Target at cfg_bus/cfg_devfn exists |
| dev_hotplug | input | 1 | Target was hot-added |
| dev_fn0_present | input | 1 | Function 0 of the target device exists |
| state_ld | input | 1 | Load address register from state_in |
| state_in | input | 32 | Restored address register value |
| state_out | output | 32 | Current address register value |

## Verification
The checks assume a well-behaved host and device. The host raises `host_req` only while `host_ready` is high, and `state_ld` arrives only while the bridge is idle. The device raises `cfg_ack` once per request and only after `cfg_req`. The presence flags must be valid in the cycle after the target fields change. The bench's host task waits for `host_ready` before driving a one-cycle strobe, and restores happen between accesses. The device models register `cfg_ack` one cycle after `cfg_req` and compute the presence flags combinationally from `cfg_bus` and `cfg_devfn`.

// File: rtl/cab_pkg.sv
`timescale 1ns/1ps
package cab_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int LANE_W  = $clog2(BYTES);
    localparam int LEN_W   = LANE_W + 1;
    localparam int BUS_W   = 8;
    localparam int FN_W    = 8;
    localparam int FUNC_W  = 3;
    localparam int OFF_W   = 8;
    localparam int LOW_W   = OFF_W + FN_W + BUS_W;
    localparam int EN_BIT  = WORD_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [WORD_W-1:0] addr;
        logic              ack;
        logic [WORD_W-1:0] rdata;
        logic              req;
        logic              we;
        logic [BUS_W-1:0]  bus;
        logic [FN_W-1:0]   devfn;
        logic [OFF_W-1:0]  regoff;
        logic [BYTES-1:0]  be;
        logic [WORD_W-1:0] wdata;
    } regs_t;
endpackage

// File: rtl/cab_decode.sv
`timescale 1ns/1ps
module cab_decode
    import cab_pkg::*;
#(
    parameter int CFG_LIMIT = 256
) (
    input  logic [LOW_W-1:0]  addr_low,
    input  logic [LANE_W-1:0] acc_off,
    input  logic [LEN_W-1:0]  acc_len,
    output logic [BUS_W-1:0]  bus,
    output logic [FN_W-1:0]   devfn,
    output logic [OFF_W-1:0]  regoff,
    output logic              in_range,
    output logic [BYTES-1:0]  be
);
    localparam int ROOM_W = OFF_W + 2;

    logic [ROOM_W-1:0] room;
    logic [LEN_W-1:0]  eff;
    logic [BYTES-1:0]  run;

    always_comb begin
        bus      = addr_low[OFF_W+FN_W +: BUS_W];
        devfn    = addr_low[OFF_W +: FN_W];
        regoff   = addr_low[OFF_W-1:0] | OFF_W'(acc_off);
        in_range = ROOM_W'(regoff) < ROOM_W'(CFG_LIMIT);
        room     = ROOM_W'(CFG_LIMIT) - ROOM_W'(regoff);
        eff      = (ROOM_W'(acc_len) < room) ? acc_len : LEN_W'(room);
        if (eff > LEN_W'(BYTES)) begin
            eff = LEN_W'(BYTES);
        end
        run = BYTES'((1 << eff) - 1);
        be  = run << regoff[LANE_W-1:0];
    end
endmodule

// File: rtl/cab_lanes.sv
`timescale 1ns/1ps
module cab_lanes
    import cab_pkg::*;
(
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [WORD_W-1:0] wr_data_in,
    output logic [WORD_W-1:0] wr_data_out,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic [BYTES-1:0]  rd_be,
    input  logic [WORD_W-1:0] rd_data_in,
    output logic [WORD_W-1:0] rd_data_out
);
    logic [BYTES-1:0]  be_r;
    logic [WORD_W-1:0] mask;

    assign be_r = rd_be >> rd_lane;

    for (genvar g = 0; g < BYTES; g++) begin : g_mask
        assign mask[g*8 +: 8] = {8{be_r[g]}};
    end

    assign wr_data_out = wr_data_in << {wr_lane, 3'b000};
    assign rd_data_out = (rd_data_in >> {rd_lane, 3'b000}) & mask;
endmodule

// File: rtl/cfg_access_bridge.sv
`timescale 1ns/1ps
module cfg_access_bridge
    import cab_pkg::*;
#(
    parameter int CFG_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [1:0]        host_off,
    input  logic [2:0]        host_len,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic              host_ack,
    output logic [31:0]       host_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [7:0]        cfg_bus,
    output logic [7:0]        cfg_devfn,
    output logic [7:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic [31:0]       cfg_rdata,
    input  logic              dev_present,
    input  logic              dev_hotplug,
    input  logic              dev_fn0_present,
    input  logic              state_ld,
    input  logic [31:0]       state_in,
    output logic [31:0]       state_out
);
    regs_t q, d;

    logic [BUS_W-1:0]  dec_bus;
    logic [FN_W-1:0]   dec_devfn;
    logic [OFF_W-1:0]  dec_regoff;
    logic              dec_in_range;
    logic [BYTES-1:0]  dec_be;
    logic [WORD_W-1:0] wr_shift;
    logic [WORD_W-1:0] rd_aligned;
    logic              orphan_fn;
    logic              full_word_wr;

    cab_decode #(.CFG_LIMIT(CFG_LIMIT)) u_dec (
        .addr_low (q.addr[LOW_W-1:0]),
        .acc_off  (host_off),
        .acc_len  (host_len),
        .bus      (dec_bus),
        .devfn    (dec_devfn),
        .regoff   (dec_regoff),
        .in_range (dec_in_range),
        .be       (dec_be)
    );

    cab_lanes u_lanes (
        .wr_lane     (dec_regoff[LANE_W-1:0]),
        .wr_data_in  (host_wdata),
        .wr_data_out (wr_shift),
        .rd_lane     (q.regoff[LANE_W-1:0]),
        .rd_be       (q.be),
        .rd_data_in  (cfg_rdata),
        .rd_data_out (rd_aligned)
    );

    // a non-zero function of a hot-added device is hidden without its function 0
    assign orphan_fn    = dev_hotplug && (q.devfn[FUNC_W-1:0] != '0) && !dev_fn0_present;
    assign full_word_wr = (host_off == '0) && (host_len == LEN_W'(BYTES));

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.req = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (host_req) begin
                    if (!host_sel) begin
                        d.ack   = 1'b1;
                        d.rdata = q.addr;
                        if (host_we && full_word_wr) begin
                            d.addr = host_wdata;
                        end
                    end else begin
                        d.we     = host_we;
                        d.bus    = dec_bus;
                        d.devfn  = dec_devfn;
                        d.regoff = dec_regoff;
                        d.be     = dec_be;
                        d.wdata  = wr_shift;
                        if (q.addr[EN_BIT] && dec_in_range) begin
                            d.st = ST_PROBE;
                        end else begin
                            d.ack   = 1'b1;
                            d.rdata = '1;
                        end
                    end
                end
            end
            ST_PROBE: begin
                if (!dev_present || orphan_fn) begin
                    d.ack   = 1'b1;
                    d.rdata = '1;
                    d.st    = ST_IDLE;
                end else begin
                    d.req = 1'b1;
                    d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cfg_ack) begin
                    d.ack   = 1'b1;
                    d.rdata = rd_aligned;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (state_ld) begin
            d.addr = state_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign host_ready = (q.st == ST_IDLE);
    assign host_ack   = q.ack;
    assign host_rdata = q.rdata;
    assign cfg_req    = q.req;
    assign cfg_we     = q.we;
    assign cfg_bus    = q.bus;
    assign cfg_devfn  = q.devfn;
    assign cfg_reg    = q.regoff;
    assign cfg_be     = q.be;
    assign cfg_wdata  = q.wdata;
    assign state_out  = q.addr;
endmodule

// File: rtl/cab_checker.sv
`timescale 1ns/1ps
module cab_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_we,
    input logic        host_sel,
    input logic [1:0]  host_off,
    input logic [2:0]  host_len,
    input logic        host_ready,
    input logic        host_ack,
    input logic        cfg_req,
    input logic [7:0]  cfg_bus,
    input logic [7:0]  cfg_devfn,
    input logic [7:0]  cfg_reg,
    input logic [3:0]  cfg_be,
    input logic        state_ld,
    input logic [31:0] state_in,
    input logic [31:0] state_out
);
    logic addr_wr_taken;
    assign addr_wr_taken = host_req && host_ready && !host_sel && host_we
                           && (host_off == 2'd0) && (host_len == 3'd4);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_out == 32'h0));

    p_addr_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_ld && !addr_wr_taken) |=> $stable(state_out));

    p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |=> ($stable(cfg_bus) && $stable(cfg_devfn) && $stable(cfg_reg)));

    p_be_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_be != 4'h0));

    p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_ld |=> (state_out == $past(state_in)));

    p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> !cfg_req);

    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> host_ready);
endmodule

bind cfg_access_bridge cab_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_off   (host_off),
    .host_len   (host_len),
    .host_ready (host_ready),
    .host_ack   (host_ack),
    .cfg_req    (cfg_req),
    .cfg_bus    (cfg_bus),
    .cfg_devfn  (cfg_devfn),
    .cfg_reg    (cfg_reg),
    .cfg_be     (cfg_be),
    .state_ld   (state_ld),
    .state_in   (state_in),
    .state_out  (state_out)
);

// File: tb/cfg_access_bridge_tb.sv
`timescale 1ns/1ps
module cfg_access_bridge_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int compared = 0;
    int failed = 0;
    int cyc = 0;

    // ---------------- main DUT ----------------
    logic        host_req = 0, host_we = 0, host_sel = 0;
    logic [1:0]  host_off = 0;
    logic [2:0]  host_len = 0;
    logic [31:0] host_wdata = 0;
    logic        host_ready, host_ack;
    logic [31:0] host_rdata;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus, cfg_devfn, cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 0;
    logic [31:0] cfg_rdata = 0;
    logic        dev_present, dev_hotplug, dev_fn0_present;
    logic        state_ld = 0;
    logic [31:0] state_in = 0;
    logic [31:0] state_out;

    cfg_access_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
        .host_off(host_off), .host_len(host_len), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_ack(host_ack), .host_rdata(host_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .dev_present(dev_present), .dev_hotplug(dev_hotplug), .dev_fn0_present(dev_fn0_present),
        .state_ld(state_ld), .state_in(state_in), .state_out(state_out)
    );

    // device model: bus 0, devfn 08/11/18/19 exist; 11 and 19 hot-added; shared dword store
    function automatic logic exists(logic [7:0] b, logic [7:0] f);
        return (b == 8'h00) && (f == 8'h08 || f == 8'h11 || f == 8'h18 || f == 8'h19);
    endfunction
    assign dev_present     = exists(cfg_bus, cfg_devfn);
    assign dev_hotplug     = (cfg_devfn == 8'h11) || (cfg_devfn == 8'h19);
    assign dev_fn0_present = exists(cfg_bus, {cfg_devfn[7:3], 3'b000});

    logic [31:0] mem [64];
    initial for (int i = 0; i < 64; i++) mem[i] = 32'h0;

    int          creq_cnt = 0;
    logic [7:0]  last_bus, last_devfn, last_reg;
    logic [3:0]  last_be;
    logic [31:0] last_wdata;
    always @(posedge clk) begin
        cfg_ack <= cfg_req;
        if (cfg_req) begin
            creq_cnt   <= creq_cnt + 1;
            last_bus   <= cfg_bus;
            last_devfn <= cfg_devfn;
            last_reg   <= cfg_reg;
            last_be    <= cfg_be;
            last_wdata <= cfg_wdata;
            if (cfg_we) begin
                for (int i = 0; i < 4; i++)
                    if (cfg_be[i]) mem[cfg_reg[7:2]][i*8 +: 8] <= cfg_wdata[i*8 +: 8];
            end else begin
                cfg_rdata <= mem[cfg_reg[7:2]];
            end
        end
    end

    // ---------------- second DUT with a short config space ----------------
    logic        h2_req = 0, h2_we = 0, h2_sel = 0;
    logic [1:0]  h2_off = 0;
    logic [2:0]  h2_len = 0;
    logic [31:0] h2_wdata = 0;
    logic        h2_ready, h2_ack;
    logic [31:0] h2_rdata;
    logic        c2_req, c2_we;
    logic [7:0]  c2_bus, c2_devfn, c2_reg;
    logic [3:0]  c2_be;
    logic [31:0] c2_wdata;
    logic        c2_ack = 0;
    logic [31:0] s2_out;
    int          c2_cnt = 0;
    logic [3:0]  c2_last_be;

    cfg_access_bridge #(.CFG_LIMIT(66)) u_dut_lim (
        .clk(clk), .rst_n(rst_n),
        .host_req(h2_req), .host_we(h2_we), .host_sel(h2_sel),
        .host_off(h2_off), .host_len(h2_len), .host_wdata(h2_wdata),
        .host_ready(h2_ready), .host_ack(h2_ack), .host_rdata(h2_rdata),
        .cfg_req(c2_req), .cfg_we(c2_we), .cfg_bus(c2_bus), .cfg_devfn(c2_devfn),
        .cfg_reg(c2_reg), .cfg_be(c2_be), .cfg_wdata(c2_wdata),
        .cfg_ack(c2_ack), .cfg_rdata(32'h4433_2211),
        .dev_present(1'b1), .dev_hotplug(1'b0), .dev_fn0_present(1'b1),
        .state_ld(1'b0), .state_in(32'h0), .state_out(s2_out)
    );

    always @(posedge clk) begin
        c2_ack <= c2_req;
        if (c2_req) begin
            c2_cnt     <= c2_cnt + 1;
            c2_last_be <= c2_be;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic sel, input logic we, input logic [1:0] off,
                       input logic [2:0] len, input logic [31:0] wd,
                       output logic [31:0] rd, output int nreq);
        int base;
        int guard;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        base = creq_cnt;
        host_req = 1; host_sel = sel; host_we = we; host_off = off; host_len = len; host_wdata = wd;
        @(negedge clk);
        host_req = 0;
        guard = 0;
        while (!host_ack && guard < 200) begin @(negedge clk); guard++; end
        rd   = host_rdata;
        nreq = creq_cnt - base;
        if (guard >= 200) check("R11 ack timeout", 32'h0, 32'h1);
    endtask

    task automatic acc2(input logic sel, input logic we, input logic [1:0] off,
                        input logic [2:0] len, input logic [31:0] wd,
                        output logic [31:0] rd, output int nreq);
        int base;
        int guard;
        @(negedge clk);
        while (!h2_ready) @(negedge clk);
        base = c2_cnt;
        h2_req = 1; h2_sel = sel; h2_we = we; h2_off = off; h2_len = len; h2_wdata = wd;
        @(negedge clk);
        h2_req = 0;
        guard = 0;
        while (!h2_ack && guard < 200) begin @(negedge clk); guard++; end
        rd   = h2_rdata;
        nreq = c2_cnt - base;
        if (guard >= 200) check("R11 ack timeout (limit instance)", 32'h0, 32'h1);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic        sel;   // 0 = address register, 1 = data window
        logic        we;
        logic [1:0]  off;
        logic [2:0]  len;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
        logic [1:0]  nreq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,2'd0,3'd4,32'h8000_0810,1'b0,32'h0,        2'd0,4'd2},  // R2 aligned write
        '{1'b0,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h8000_0810,2'd0,4'd3},  // R3
        '{1'b1,1'b1,2'd0,3'd4,32'hA1B2_C3D4,1'b0,32'h0,        2'd1,4'd5},  // R5
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'hA1B2_C3D4,2'd1,4'd5},  // R5
        '{1'b1,1'b0,2'd1,3'd1,32'h0,        1'b1,32'h0000_00C3,2'd1,4'd6},  // R6 byte lane 1
        '{1'b1,1'b0,2'd2,3'd2,32'h0,        1'b1,32'h0000_A1B2,2'd1,4'd6},  // R6 halfword lanes 2-3
        '{1'b1,1'b1,2'd3,3'd1,32'h0000_005A,1'b0,32'h0,        2'd1,4'd6},  // R6 byte write lane 3
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h5AB2_C3D4,2'd1,4'd6},  // R6
        '{1'b0,1'b1,2'd2,3'd4,32'h0,        1'b0,32'h0,        2'd0,4'd2},  // R2 unaligned ignored
        '{1'b0,1'b1,2'd0,3'd2,32'h0,        1'b0,32'h0,        2'd0,4'd2},  // R2 narrow ignored
        '{1'b0,1'b0,2'd2,3'd1,32'h0,        1'b1,32'h8000_0810,2'd0,4'd3},  // R3 any offset
        '{1'b0,1'b1,2'd0,3'd4,32'h0000_0810,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'hFFFF_FFFF,2'd0,4'd4},  // R4 disabled read
        '{1'b1,1'b1,2'd0,3'd4,32'h1111_1111,1'b0,32'h0,        2'd0,4'd4},  // R4 disabled write
        '{1'b0,1'b1,2'd0,3'd4,32'h8000_0810,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h5AB2_C3D4,2'd1,4'd4},  // R4 write was dropped
        '{1'b1,1'b0,2'd2,3'd4,32'h0,        1'b1,32'h0000_5AB2,2'd1,4'd6},  // R6 lanes cut at dword
        '{1'b0,1'b1,2'd0,3'd4,32'h8000_0811,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b0,2'd2,3'd1,32'h0,        1'b1,32'h0000_005A,2'd1,4'd5},  // R5 offset OR -> 0x13
        '{1'b0,1'b1,2'd0,3'd4,32'h8000_1110,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'hFFFF_FFFF,2'd0,4'd8},  // R8 orphan read
        '{1'b1,1'b1,2'd0,3'd4,32'h2222_2222,1'b0,32'h0,        2'd0,4'd8},  // R8 orphan write
        '{1'b0,1'b1,2'd0,3'd4,32'h8000_1910,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h5AB2_C3D4,2'd1,4'd8},  // R8 fn0 present
        '{1'b0,1'b1,2'd0,3'd4,32'h8001_0810,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'hFFFF_FFFF,2'd0,4'd7},  // R7 no bus 1
        '{1'b0,1'b1,2'd0,3'd4,32'h8000_2010,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'hFFFF_FFFF,2'd0,4'd7},  // R7 absent devfn
        '{1'b0,1'b1,2'd0,3'd4,32'h8000_08FC,1'b0,32'h0,        2'd0,4'd2},  // R2
        '{1'b1,1'b1,2'd0,3'd4,32'h0102_0304,1'b0,32'h0,        2'd1,4'd9},  // R9
        '{1'b1,1'b0,2'd3,3'd4,32'h0,        1'b1,32'h0000_0001,2'd1,4'd9},  // R9 clip to 1 byte
        '{1'b1,1'b0,2'd2,3'd4,32'h0,        1'b1,32'h0000_0102,2'd1,4'd9}   // R9 clip to 2 bytes
    };

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            compared++;
            failed++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] saved;
        int          n;
        string       tag;

        repeat (3) @(negedge clk);
        check("R1 address register after reset", state_out, 32'h0);
        check("R1 ready after reset", {31'h0, host_ready}, 32'h1);
        rst_n = 1'b1;
        acc(1'b1, 1'b0, 2'd0, 3'd4, 32'h0, rd, n);
        check("R1 data read after reset", rd, 32'hFFFF_FFFF);
        check("R1 no request after reset", n, 0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].sel, VEC[i].we, VEC[i].off, VEC[i].len, VEC[i].wdata, rd, n);
            tag = $sformatf("R%0d vector %0d", VEC[i].rq, i);
            if (VEC[i].chk) check({tag, " data"}, rd, VEC[i].exp);
            check({tag, " request count"}, n, 32'(VEC[i].nreq));
        end

        // R5 fields of the last forwarded request (addr 0x800008FC, off 2)
        check("R5 bus field", {24'h0, last_bus}, 32'h0);
        check("R5 devfn field", {24'h0, last_devfn}, 32'h08);
        check("R5 register offset", {24'h0, last_reg}, 32'hFE);
        check("R6 byte enables clipped", {28'h0, last_be}, 32'hC);

        // R6 write lane placement
        acc(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_0820, rd, n);
        acc(1'b1, 1'b1, 2'd1, 3'd2, 32'h0000_BEEF, rd, n);
        check("R6 write byte enables", {28'h0, last_be}, 32'h6);
        check("R6 write data shifted", last_wdata, 32'h00BE_EF00);

        // R10 save, reset, restore
        acc(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_08FC, rd, n);
        saved = state_out;
        check("R10 state_out shows register", saved, 32'h8000_08FC);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 register cleared by reset", state_out, 32'h0);
        state_ld = 1'b1; state_in = saved;
        @(negedge clk); state_ld = 1'b0;
        check("R10 register restored", state_out, 32'h8000_08FC);
        acc(1'b1, 1'b0, 2'd0, 3'd4, 32'h0, rd, n);
        check("R10 access after restore", rd, 32'h0102_0304);

        // R9 short config space (limit 66)
        acc2(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_0840, rd, n);
        acc2(1'b1, 1'b0, 2'd0, 3'd4, 32'h0, rd, n);
        check("R9 clipped read data", rd, 32'h0000_2211);
        check("R9 clipped byte enables", {28'h0, c2_last_be}, 32'h3);
        acc2(1'b1, 1'b0, 2'd1, 3'd4, 32'h0, rd, n);
        check("R9 one byte left", rd, 32'h0000_0022);
        acc2(1'b1, 1'b0, 2'd2, 3'd1, 32'h0, rd, n);
        check("R9 offset at limit reads ones", rd, 32'hFFFF_FFFF);
        check("R9 offset at limit no request", n, 0);
        acc2(1'b1, 1'b1, 2'd3, 3'd1, 32'hFF, rd, n);
        check("R9 write beyond limit dropped", n, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
        $finish;
    end
endmodule